// File: doc/BRIEF.md
# Internal Control Register File

This block holds the privileged control registers of a processor core. A single index port selects one of 28 registers for a read, a write, or both in the same cycle. Each register has its own write rule: full storage, a per-register write mask, clear on any write, read-only or write-only. One register returns a mix on read. Its upper half comes from storage and its lower half from a free-running cycle counter inside the block.

An access that is not allowed does not change any state. This covers a write to a read-only index, a read of a write-only index, and any access to an unused index. Such an access raises a one-cycle error pulse instead. While the speculative input is high, all writes are dropped with no side effect. Each accepted write emits a strobe that carries the written index, so neighbouring logic such as translation buffers can react to it.

Top module: `icr_file`

## Requirements
- R1: After reset every register reads zero, except the memory control register at index 25, which reads 0x6.
- R2: Read data and the error pulse appear in the cycle after the request. Read data holds its last value when no read is made. Scratch registers 0–7, memory control 25 and the cycle register 8 store all 64 bits of a write.
- R3: A read of index 8 returns the stored bits 63:32 above the 32-bit cycle counter value in the request cycle. The counter is zero in the first cycle after reset and counts up by one each clock.
- R4: A write to the exception-address register 9 stores the data with bit 1 forced to zero.
- R5: The trap request and trap enable registers 10 and 11 keep only data bits 3:0.
- R6: The mode registers 12 and 13 (readable) and 14 (write-only) keep only data bits 4:3 (mask 0x18).
- R7: The following write masks apply:
  - index 15: 0xffffff0300
  - indices 16 and 17: bits 63:30
  - index 18: 0x1ffb
  - indices 19 and 20: 0x3f
  - index 21: 0x7f0
  - index 22: bits 63:57
- R8: Any write to index 23 or 24 clears that register to zero, whatever the data.
- R9: Index 26 is read-only and reads zero. A write to it raises the error pulse, leaves the register unchanged and emits no strobe.
- R10: Indices 14 and 27 are write-only. A read of either raises the error pulse and returns zero. A write to either is accepted.
- R11: Indices 28–31 are invalid. Any read or write to them raises the error pulse, a read returns zero, and no state changes.
- R12: While spec is high, a write changes nothing, emits no strobe and raises no error. Reads are unaffected.
- R13: Each accepted write pulses wr_stb one cycle later, with wr_stb_idx equal to the written index.
- R14: A read and a write to the same index in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx | input | 5 | Register index for read and write |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| spec | input | 1 | Speculative: suppresses writes |
| rd_data | output | 64 | Read result, registered |
| acc_err | output | 1 | Illegal-access pulse, registered |
| wr_stb | output | 1 | Accepted-write pulse |
| wr_stb_idx | output | 5 | Index of the accepted write |

## Verification
A wrong mask or a wrong clear rule leaves a corrupted stored value. That value shows on rd_data only on the next read of the same index, so the bench reads back most registers soon after writing them. A wrong decode of the access class shows one cycle after the request, as a missing or extra error pulse or strobe. A counter that is off by one shows in the low half of every read of the cycle register, one cycle after the request.

// File: rtl/icr_pkg.sv
package icr_pkg;
   localparam int ICR_DW   = 64;
   localparam int ICR_NREG = 28;

   typedef enum logic [2:0] {
      K_PLAIN, K_MASK, K_CLEAR, K_RDONLY, K_WRONLY, K_CYCLE, K_NONE
   } kind_e;

   localparam int unsigned IX_CYCLE  = 8;
   localparam int unsigned IX_EXCADR = 9;
   localparam int unsigned IX_MEMCTL = 25;

   // access class of each index
   function automatic kind_e kind_of(int unsigned i);
      kind_e k;
      if (i < 8)                       k = K_PLAIN;
      else if (i == IX_CYCLE)          k = K_CYCLE;
      else if (i >= 9 && i <= 13)      k = K_MASK;
      else if (i == 14 || i == 27)     k = K_WRONLY;
      else if (i >= 15 && i <= 22)     k = K_MASK;
      else if (i == 23 || i == 24)     k = K_CLEAR;
      else if (i == IX_MEMCTL)         k = K_PLAIN;
      else if (i == 26)                k = K_RDONLY;
      else                             k = K_NONE;
      return k;
   endfunction

   // bits kept on a write
   function automatic logic [ICR_DW-1:0] mask_of(int unsigned i);
      logic [ICR_DW-1:0] m;
      case (i)
         9:       m = ~64'h2;
         10, 11:  m = 64'hf;
         12, 13,
         14:      m = 64'h18;
         15:      m = 64'hff_ffff_0300;
         16, 17:  m = 64'hffff_ffff_c000_0000;
         18:      m = 64'h1ffb;
         19, 20:  m = 64'h3f;
         21:      m = 64'h7f0;
         22:      m = 64'hfe00_0000_0000_0000;
         default: m = '1;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/icr_decode.sv
module icr_decode #(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic             valid_o,
   output icr_pkg::kind_e   kind_o
);
   import icr_pkg::*;

   always_comb begin
      kind_o = K_NONE;
      for (int j = 0; j < ICR_NREG; j++) begin
         if (idx_i == IDX_W'(j)) kind_o = kind_of(j);
      end
      valid_o = (kind_o != K_NONE);
   end
endmodule

// File: rtl/icr_cyc_ctr.sv
module icr_cyc_ctr #(
   parameter int CTR_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CTR_W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (rst) cnt_o <= '0;
      else     cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/icr_cell.sv
module icr_cell #(
   parameter int             DW    = 64,
   parameter bit             CLEAR = 1'b0,
   parameter logic [DW-1:0]  WMASK = '1,
   parameter logic [DW-1:0]  RSTV  = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] q_o
);
   if (CLEAR) begin : g_clr
      wire clr_unused = ^wdata_i;
      always_ff @(posedge clk) begin
         if (rst)       q_o <= RSTV;
         else if (we_i) q_o <= '0;
      end
      // R8
      clr_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
         we_i |=> (q_o == '0));
   end else begin : g_store
      always_ff @(posedge clk) begin
         if (rst)       q_o <= RSTV;
         else if (we_i) q_o <= wdata_i & WMASK;
      end
   end
endmodule

// File: rtl/icr_file.sv
module icr_file #(
   parameter int            IDX_W      = 5,
   parameter int            DATA_W     = 64,
   parameter int            CTR_W      = 32,
   parameter logic [63:0]   MEMCTL_RST = 64'h6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              spec,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_err,
   output logic              wr_stb,
   output logic [IDX_W-1:0]  wr_stb_idx
);
   import icr_pkg::*;

   localparam int NREG = ICR_NREG;

   if (DATA_W != ICR_DW) begin : g_bad_dw
      $error("icr_file: DATA_W must equal the package register width");
   end
   if ((1 << IDX_W) < NREG) begin : g_bad_idx
      $error("icr_file: IDX_W too narrow for the register count");
   end
   if (CTR_W < 1 || CTR_W >= DATA_W) begin : g_bad_ctr
      $error("icr_file: CTR_W out of range");
   end

   logic              valid;
   kind_e             kind;
   logic [CTR_W-1:0]  ctr;
   logic [DATA_W-1:0] q_arr [NREG];
   logic [DATA_W-1:0] sel_q;
   logic [DATA_W-1:0] rd_val;
   logic              wr_ok, rd_bad, wr_bad;

   icr_decode #(.IDX_W(IDX_W)) u_dec (
      .idx_i(idx), .valid_o(valid), .kind_o(kind));

   icr_cyc_ctr #(.CTR_W(CTR_W)) u_ctr (
      .clk(clk), .rst(rst), .cnt_o(ctr));

   assign wr_ok  = wr_en && !spec && valid && (kind != K_RDONLY);
   assign wr_bad = wr_en && !spec && (!valid || kind == K_RDONLY);
   assign rd_bad = rd_en && (!valid || kind == K_WRONLY);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam kind_e       KI = kind_of(i);
      localparam logic [63:0] RV = (i == IX_MEMCTL) ? MEMCTL_RST : 64'h0;
      logic we;
      assign we = wr_ok && (idx == IDX_W'(i));
      icr_cell #(
         .DW   (DATA_W),
         .CLEAR(KI == K_CLEAR),
         .WMASK(mask_of(i)),
         .RSTV (RV)
      ) u_cell (
         .clk(clk), .rst(rst), .we_i(we), .wdata_i(wdata), .q_o(q_arr[i]));
   end

   always_comb begin
      sel_q = '0;
      for (int j = 0; j < NREG; j++) begin
         if (idx == IDX_W'(j)) sel_q = q_arr[j];
      end
      if (rd_bad)                rd_val = '0;
      else if (kind == K_CYCLE)  rd_val = {sel_q[DATA_W-1:CTR_W], ctr};
      else                       rd_val = sel_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data    <= '0;
         acc_err    <= 1'b0;
         wr_stb     <= 1'b0;
         wr_stb_idx <= '0;
      end else begin
         if (rd_en) rd_data <= rd_val;
         acc_err <= rd_bad || wr_bad;
         wr_stb  <= wr_ok;
         if (wr_ok) wr_stb_idx <= idx;
      end
   end

   // R11
   bad_idx_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !valid) |=> (acc_err && rd_data == '0));
   // R12
   spec_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && spec && !rd_en) |=> (!acc_err && !wr_stb));
   // R13
   stb_idx_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !spec && valid && kind != K_RDONLY) |=>
         (wr_stb && wr_stb_idx == $past(idx)));
   // R9
   ro_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !spec && kind == K_RDONLY) |=> (acc_err && !wr_stb));
   // R3
   cyc_low_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && kind == K_CYCLE) |=> (rd_data[CTR_W-1:0] == $past(ctr)));
endmodule

// File: tb/icr_file_tb.sv
module icr_file_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  idx = '0;
   logic [63:0] wdata = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0, spec = 1'b0;
   logic [63:0] rd_data;
   logic        acc_err, wr_stb;
   logic [4:0]  wr_stb_idx;

   int n_chk = 0, n_bad = 0;
   logic [63:0] model [28];
   logic [63:0] last_rd = '0;
   logic [31:0] bcnt = '0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) bcnt <= '0;
      else     bcnt <= bcnt + 1;
   end

   icr_file u_dut (
      .clk(clk), .rst(rst), .idx(idx), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .spec(spec), .rd_data(rd_data), .acc_err(acc_err),
      .wr_stb(wr_stb), .wr_stb_idx(wr_stb_idx));

   // 0 plain/masked, 1 clear, 2 read-only, 3 write-only, 4 cycle, 5 invalid
   function automatic int kind(input int i);
      if (i == 8) return 4;
      if (i == 23 || i == 24) return 1;
      if (i == 26) return 2;
      if (i == 14 || i == 27) return 3;
      if (i >= 28) return 5;
      return 0;
   endfunction

   function automatic logic [63:0] msk(input int i);
      case (i)
         9:          return ~64'h2;
         10, 11:     return 64'hf;
         12, 13, 14: return 64'h18;
         15:         return 64'hff_ffff_0300;
         16, 17:     return 64'hffff_ffff_c000_0000;
         18:         return 64'h1ffb;
         19, 20:     return 64'h3f;
         21:         return 64'h7f0;
         22:         return 64'hfe00_0000_0000_0000;
         default:    return '1;
      endcase
   endfunction

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge after checking
   task automatic acc(input bit r, input bit w, input int ix,
                      input logic [63:0] d, input bit sp, input string tag);
      int k;
      bit e_rerr, e_werr, e_ok;
      logic [63:0] e_rd;
      k = kind(ix);
      idx = 5'(ix); wdata = d; rd_en = r; wr_en = w; spec = sp;
      e_rerr = r && (k == 5 || k == 3);
      e_werr = w && !sp && (k == 5 || k == 2);
      e_ok   = w && !sp && k != 5 && k != 2;
      if (r) begin
         if (e_rerr)      e_rd = '0;
         else if (k == 4) e_rd = {model[ix][63:32], bcnt};
         else             e_rd = model[ix];
         last_rd = e_rd;
      end
      @(negedge clk);
      chk({tag, " err"}, {63'b0, acc_err}, {63'b0, e_rerr || e_werr});
      chk({tag, " stb"}, {63'b0, wr_stb}, {63'b0, e_ok});
      if (e_ok) chk({tag, " stb_idx"}, {59'b0, wr_stb_idx}, 64'(ix));
      chk({tag, " rdata"}, rd_data, last_rd);
      if (e_ok) model[ix] = (k == 1) ? 64'h0 : (d & msk(ix));
      rd_en = 1'b0; wr_en = 1'b0; spec = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 28; i++) model[i] = '0;
      model[25] = 64'h6;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset err", {63'b0, acc_err}, 64'h0);
      chk("R1 reset stb", {63'b0, wr_stb}, 64'h0);
      for (int i = 0; i < 28; i++) if (kind(i) != 3) acc(1, 0, i, '0, 0, "R1");
      // R2 scratch and memory control full width
      acc(0, 1, 3, 64'hffff_ffff_ffff_ffff, 0, "R2");
      acc(1, 0, 3, '0, 0, "R2");
      acc(0, 1, 25, 64'h0123_4567_89ab_cdef, 0, "R2");
      acc(1, 0, 25, '0, 0, "R2");
      // R3 cycle splice, read twice
      acc(0, 1, 8, 64'hdead_beef_1234_5678, 0, "R3");
      acc(1, 0, 8, '0, 0, "R3");
      repeat (5) @(negedge clk);
      acc(1, 0, 8, '0, 0, "R3");
      // R4 .. R8 masks and clear
      acc(0, 1, 9, '1, 0, "R4");  acc(1, 0, 9, '0, 0, "R4");
      acc(0, 1, 10, '1, 0, "R5"); acc(1, 0, 10, '0, 0, "R5");
      acc(0, 1, 11, '1, 0, "R5"); acc(1, 0, 11, '0, 0, "R5");
      acc(0, 1, 12, '1, 0, "R6"); acc(1, 0, 12, '0, 0, "R6");
      acc(0, 1, 14, '1, 0, "R6");
      for (int i = 15; i <= 22; i++) begin
         acc(0, 1, i, '1, 0, "R7"); acc(1, 0, i, '0, 0, "R7");
      end
      acc(0, 1, 23, '1, 0, "R8"); acc(1, 0, 23, '0, 0, "R8");
      acc(0, 1, 24, 64'h5, 0, "R8"); acc(1, 0, 24, '0, 0, "R8");
      // R9 .. R11 illegal accesses
      acc(0, 1, 26, '1, 0, "R9");  acc(1, 0, 26, '0, 0, "R9");
      acc(1, 0, 27, '0, 0, "R10"); acc(0, 1, 27, 64'h77, 0, "R10");
      acc(1, 0, 14, '0, 0, "R10");
      acc(1, 0, 30, '0, 0, "R11"); acc(0, 1, 29, '1, 0, "R11");
      acc(1, 1, 31, '1, 0, "R11");
      // R12 speculative write
      acc(0, 1, 5, 64'haaaa, 1, "R12"); acc(1, 0, 5, '0, 0, "R12");
      acc(1, 1, 25, 64'h99, 1, "R12"); acc(1, 0, 25, '0, 0, "R12");
      // R13 strobe with index, R14 read-before-write
      acc(0, 1, 17, 64'h1_0000_0000, 0, "R13");
      acc(1, 1, 6, 64'h1111, 0, "R14"); acc(1, 1, 6, 64'h2222, 0, "R14");
      acc(1, 0, 6, '0, 0, "R14");
      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         int ix;
         logic [63:0] d;
         ix = int'($urandom_range(0, 31));
         d  = {$urandom, $urandom};
         acc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, ix, d,
             $urandom_range(0, 7) == 0, "R2 random");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule